// File: doc/BRIEF.md
# Atomic-update PTP time-of-day counter

This block keeps a time-of-day value for packet timestamping. It holds three counts: nanoseconds, a fractional nanosecond part and seconds. While counting is enabled, every clock adds a programmable 32.32 fixed-point nanosecond step to the nanosecond:fraction pair. The block also tracks two boundaries, the current second start and the next second start. When the nanosecond count reaches the next boundary, the seconds count goes up by one and both boundaries move forward by the rollover period.

Software changes the time without a read-modify-write of the running counter. It first writes staging registers: nanoseconds, fraction, seconds, and the current and next boundaries. It then writes a 3-bit opcode into the config register. On the edge after that write, the counter does one of three things in a single cycle. It loads the staged absolute time, or it adds the staged offset, or it subtracts the staged offset. The opcode field then clears itself. Software must stage consistent values for a load: the seconds equal to ns divided by the period, the current boundary equal to seconds times the period, and the next boundary equal to the current boundary plus one period.

A packed timestamp is always present on an output. It carries the seconds in the upper half and the nanoseconds within the second in the lower half. The registers sit on a plain write port (valid, address, data) and a combinational read port.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, the timestamp is 0, the config register reads 0, the staged ns, fraction, seconds and current boundary read 0, and the staged next boundary and the period register read the ROLL_RST parameter.
- R2: While config bit 0 (enable) is 1 and no opcode is pending, each clock adds the 64-bit step register (bits 63:32 whole ns, bits 31:0 fraction) to the ns:fraction pair, with carry from the fraction into ns. While enable is 0 and no opcode is pending, the time holds.
- R3: When a normal count step makes ns greater than or equal to the next boundary, the seconds count rises by one, the current boundary takes the old next boundary, and the next boundary grows by the period, all on the same edge.
- R4: Opcode 1 (load), written to config bits 28:26, makes the counter load the staged ns, fraction, seconds, current boundary and next boundary on the edge after the config write. No step is added on that edge. Enable does not gate the load.
- R5: Opcode 3 (add) adds the staged ns:fraction to the running pair on the edge after the config write. If the result reaches the next boundary, the seconds and boundaries advance as in R3.
- R6: Opcode 4 (subtract) subtracts the staged ns:fraction on the edge after the config write. If the result falls below the current boundary, the seconds count drops by one, the next boundary takes the old current boundary, and the current boundary drops by the period.
- R7: When a subtract would take the ns:fraction pair below zero, ns and fraction become 0, the seconds count and the current boundary become 0, and the next boundary becomes the period.
- R8: Any nonzero opcode clears to 0 one cycle after it is written, unless a new config write arrives. Opcodes other than 1, 3 and 4 change nothing beyond normal counting.
- R9: The timestamp output and register 8 carry the seconds in bits 63:32 and, in bits 31:0, the ns count minus the current boundary.
- R10: Register word addresses are as follows. 0 is config. 1 is the step. 2, 3, 4, 5 and 6 are the staged ns, fraction, seconds, current boundary and next boundary. 7 is the period. 8 is the timestamp, and 9 is the raw running ns, both read-only. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 64 | Register read data, combinational from rd_addr |
| tstamp | output | 64 | Packed seconds / nanoseconds-within-second time |

## Verification
The bench builds the block with ROLL_RST set to 1000 and keeps the 4 ns reset step. With a rollover period of 1000 ns, a second boundary comes every couple of hundred cycles. Normal rollovers, loads next to a boundary, and adds and subtracts that cross a boundary in either direction all fit in a short run. A step of 4.5 ns and staged fractions with the top bits set bring fraction carries and borrows into play. A large subtract with counting paused reaches the saturate-to-zero case.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int NS_W   = 64;
  localparam int FR_W   = 32;
  localparam int SEC_W  = 32;
  localparam int PER_W  = 32;
  localparam int INC_W  = 64;
  localparam int SUB_W  = 32;
  localparam int DW     = 64;
  localparam int AW     = 4;
  localparam int TS_W   = SEC_W + SUB_W;
  localparam int FX_W   = NS_W + FR_W;

  localparam int EN_BIT = 0;
  localparam int OP_LO  = 26;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_IDLE = 3'd0;
  localparam logic [OP_W-1:0] OP_SET  = 3'd1;
  localparam logic [OP_W-1:0] OP_INC  = 3'd3;
  localparam logic [OP_W-1:0] OP_DEC  = 3'd4;

  localparam logic [AW-1:0] A_CFG     = 4'd0;
  localparam logic [AW-1:0] A_INCR    = 4'd1;
  localparam logic [AW-1:0] A_STG_NS  = 4'd2;
  localparam logic [AW-1:0] A_STG_FR  = 4'd3;
  localparam logic [AW-1:0] A_STG_SEC = 4'd4;
  localparam logic [AW-1:0] A_STG_CUR = 4'd5;
  localparam logic [AW-1:0] A_STG_NXT = 4'd6;
  localparam logic [AW-1:0] A_PERIOD  = 4'd7;
  localparam logic [AW-1:0] A_TSTAMP  = 4'd8;
  localparam logic [AW-1:0] A_NOW_NS  = 4'd9;

  // one complete time value: running counter or staged copy
  typedef struct packed {
    logic [NS_W-1:0]  ns;
    logic [FR_W-1:0]  fr;
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  cur;
    logic [NS_W-1:0]  nxt;
  } tod_t;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter logic [PER_W-1:0] ROLL_RST = 32'd1000000000,
  parameter logic [INC_W-1:0] INCR_RST = 64'h0000_0004_0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             en,
  output logic [OP_W-1:0]  op,
  output logic [INC_W-1:0] incr,
  output logic [PER_W-1:0] period,
  output tod_t             stg
);
  localparam tod_t STG_RST = '{ns: '0, fr: '0, sec: '0, cur: '0,
                               nxt: NS_W'(ROLL_RST)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      op     <= OP_IDLE;
      incr   <= INCR_RST;
      period <= ROLL_RST;
      stg    <= STG_RST;
    end else begin
      // a pending opcode lives for exactly one cycle
      if (op != OP_IDLE) op <= OP_IDLE;
      if (wr_valid) begin
        case (wr_addr)
          A_CFG: begin
            en <= wr_data[EN_BIT];
            op <= wr_data[OP_LO +: OP_W];
          end
          A_INCR:    incr    <= wr_data[INC_W-1:0];
          A_STG_NS:  stg.ns  <= wr_data[NS_W-1:0];
          A_STG_FR:  stg.fr  <= wr_data[FR_W-1:0];
          A_STG_SEC: stg.sec <= wr_data[SEC_W-1:0];
          A_STG_CUR: stg.cur <= wr_data[NS_W-1:0];
          A_STG_NXT: stg.nxt <= wr_data[NS_W-1:0];
          A_PERIOD:  period  <= wr_data[PER_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter logic [PER_W-1:0] ROLL_RST = 32'd1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OP_W-1:0]  op,
  input  logic [INC_W-1:0] incr,
  input  logic [PER_W-1:0] period,
  input  tod_t             stg,
  output tod_t             now
);
  localparam tod_t NOW_RST = '{ns: '0, fr: '0, sec: '0, cur: '0,
                               nxt: NS_W'(ROLL_RST)};

  logic [FX_W-1:0] acc, stg_fx, add_src, sum, dif;
  logic [NS_W-1:0] per_ns;
  logic            under;
  tod_t            nx;

  assign acc     = {now.ns, now.fr};
  assign stg_fx  = {stg.ns, stg.fr};
  assign per_ns  = NS_W'(period);
  // one adder serves both the per-clock step and the atomic add
  assign add_src = (op == OP_INC) ? stg_fx : FX_W'(incr);
  assign sum     = acc + add_src;
  assign dif     = acc - stg_fx;
  assign under   = stg_fx > acc;

  always_comb begin
    nx = now;
    case (op)
      OP_SET: nx = stg;
      OP_DEC: begin
        if (under) begin
          nx     = '0;
          nx.nxt = per_ns;
        end else begin
          {nx.ns, nx.fr} = dif;
          if (dif[FX_W-1:FR_W] < now.cur) begin
            nx.sec = now.sec - 1'b1;
            nx.nxt = now.cur;
            nx.cur = now.cur - per_ns;
          end
        end
      end
      default: begin
        if (op == OP_INC || en) begin
          {nx.ns, nx.fr} = sum;
          if (sum[FX_W-1:FR_W] >= now.nxt) begin
            nx.sec = now.sec + 1'b1;
            nx.cur = now.nxt;
            nx.nxt = now.nxt + per_ns;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= NOW_RST;
    else        now <= nx;
  end
endmodule

// File: rtl/ptp_tod_rdmux.sv
module ptp_tod_rdmux
  import ptp_tod_pkg::*;
(
  input  logic             en,
  input  logic [OP_W-1:0]  op,
  input  logic [INC_W-1:0] incr,
  input  logic [PER_W-1:0] period,
  input  tod_t             stg,
  input  tod_t             now,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [TS_W-1:0]  tstamp
);
  logic [NS_W-1:0] sub;
  logic [DW-1:0]   cfg_w;
  logic            unused_sub_hi;

  assign sub           = now.ns - now.cur;
  assign tstamp        = {now.sec, sub[SUB_W-1:0]};
  assign unused_sub_hi = ^sub[NS_W-1:SUB_W];

  always_comb begin
    cfg_w                  = '0;
    cfg_w[EN_BIT]          = en;
    cfg_w[OP_LO +: OP_W]   = op;
  end

  always_comb begin
    case (rd_addr)
      A_CFG:     rd_data = cfg_w;
      A_INCR:    rd_data = DW'(incr);
      A_STG_NS:  rd_data = DW'(stg.ns);
      A_STG_FR:  rd_data = DW'(stg.fr);
      A_STG_SEC: rd_data = DW'(stg.sec);
      A_STG_CUR: rd_data = DW'(stg.cur);
      A_STG_NXT: rd_data = DW'(stg.nxt);
      A_PERIOD:  rd_data = DW'(period);
      A_TSTAMP:  rd_data = DW'(tstamp);
      A_NOW_NS:  rd_data = DW'(now.ns);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter logic [PER_W-1:0] ROLL_RST = 32'd1000000000,
  parameter logic [INC_W-1:0] INCR_RST = 64'h0000_0004_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [TS_W-1:0] tstamp
);
  logic             cfg_en;
  logic [OP_W-1:0]  cfg_op;
  logic [INC_W-1:0] incr_q;
  logic [PER_W-1:0] period_q;
  tod_t             tod_stg;
  tod_t             tod_now;

  ptp_tod_regs #(.ROLL_RST(ROLL_RST), .INCR_RST(INCR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .en(cfg_en), .op(cfg_op), .incr(incr_q),
    .period(period_q), .stg(tod_stg)
  );

  ptp_tod_core #(.ROLL_RST(ROLL_RST)) u_core (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .op(cfg_op), .incr(incr_q),
    .period(period_q), .stg(tod_stg), .now(tod_now)
  );

  ptp_tod_rdmux u_rdmux (
    .en(cfg_en), .op(cfg_op), .incr(incr_q), .period(period_q),
    .stg(tod_stg), .now(tod_now), .rd_addr(rd_addr), .rd_data(rd_data),
    .tstamp(tstamp)
  );
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
  import ptp_tod_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic [AW-1:0]   wr_addr,
  input logic            en,
  input logic [OP_W-1:0] op,
  input tod_t            stg,
  input tod_t            now
);
  // R4
  set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> (now == $past(stg)));

  // R8
  op_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_IDLE) |=> ((op == OP_IDLE) || $past(wr_valid && (wr_addr == A_CFG))));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && op == OP_IDLE) |=> ($stable(now.ns) && $stable(now.fr) && $stable(now.sec)));

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_IDLE) |=> ((now.sec == $past(now.sec)) || (now.sec == $past(now.sec) + 1'b1)));

  // R7
  dec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC && {stg.ns, stg.fr} > {now.ns, now.fr})
    |=> (now.ns == '0 && now.fr == '0 && now.sec == '0 && now.cur == '0));
endmodule

bind ptp_tod_clock ptp_tod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .en(cfg_en), .op(cfg_op), .stg(tod_stg), .now(tod_now)
);

// File: tb/ptp_tod_clock_bench.sv
`timescale 1ns/1ps
module ptp_tod_clock_bench;
  localparam longint unsigned PER = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] tstamp;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // reference model, time kept as 64-bit ns plus 32-bit fraction
  longint unsigned m_ns = 0, m_incr = 64'h4_0000_0000, s_ns = 0;
  int unsigned     m_fr = 0, s_fr = 0;
  bit              m_en = 0;
  bit [2:0]        m_op = 0;

  always #2 clk = ~clk;

  ptp_tod_clock #(.ROLL_RST(32'd1000)) u_ptp_tod_clock (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tstamp(tstamp)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void m_add(longint unsigned d_ns, int unsigned d_fr);
    longint unsigned t;
    t    = longint'(m_fr) + longint'(d_fr);
    m_fr = t[31:0];
    m_ns = m_ns + d_ns + t[32];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ns = 0; m_fr = 0; m_en = 0; m_op = 0; m_incr = 64'h4_0000_0000;
      s_ns = 0; s_fr = 0;
    end else begin
      case (m_op)
        3'd1: begin m_ns = s_ns; m_fr = s_fr; end
        3'd3: m_add(s_ns, s_fr);
        3'd4: begin
          if (m_ns < s_ns || (m_ns == s_ns && m_fr < s_fr)) begin
            m_ns = 0; m_fr = 0;
          end else begin
            m_ns = m_ns - s_ns - ((m_fr < s_fr) ? 1 : 0);
            m_fr = m_fr - s_fr;
          end
        end
        default: if (m_en) m_add(m_incr >> 32, m_incr[31:0]);
      endcase
      m_op = 0;
      if (wr_valid) begin
        case (wr_addr)
          4'd0: begin m_en = wr_data[0]; m_op = wr_data[28:26]; end
          4'd1: m_incr = wr_data;
          4'd2: s_ns = wr_data;
          4'd3: s_fr = wr_data[31:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [63:0] exp_ts();
    return {32'(m_ns / PER), 32'(m_ns % PER)};
  endfunction

  // compare the timestamp with the model on every clock (R9 format)
  always @(negedge clk) begin
    if (rst_n && cmp_on) chk({cur_req, " R9 tstamp"}, tstamp, exp_ts());
  end

  task automatic wr(logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // stage a consistent absolute time, then issue a load
  task automatic do_set(longint unsigned ns, int unsigned fr, bit en);
    longint unsigned sec;
    sec = ns / PER;
    wr(4'd2, ns);
    wr(4'd3, 64'(fr));
    wr(4'd4, sec);
    wr(4'd5, sec * PER);
    wr(4'd6, sec * PER + PER);
    wr(4'd0, (64'd1 << 26) | 64'(en));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    cur_req = "R1";
    rd(4'd8, v); chk("R1 tstamp reg", v, 64'd0);
    rd(4'd0, v); chk("R1 cfg", v, 64'd0);
    rd(4'd2, v); chk("R1 staged ns", v, 64'd0);
    rd(4'd5, v); chk("R1 staged cur", v, 64'd0);
    rd(4'd6, v); chk("R1 staged nxt", v, 64'd1000);
    rd(4'd7, v); chk("R10 period", v, 64'd1000);
    rd(4'd1, v); chk("R10 step", v, 64'h4_0000_0000);
    rd(4'd15, v); chk("R10 unmapped", v, 64'd0);

    cur_req = "R2/R3";
    wr(4'd1, 64'h4_8000_0000);
    wr(4'd0, 64'd1);
    idle(600);
    rd(4'd9, v); chk("R2 raw ns", v, m_ns);

    cur_req = "R4";
    do_set(64'd124990, 32'h4000_0000, 1'b1);
    rd(4'd0, v); chk("R8 op cleared after load", v, 64'd1);
    rd(4'd9, v); chk("R4 raw ns after load", v, m_ns);
    idle(40);

    cur_req = "R5";
    wr(4'd2, 64'd700);
    wr(4'd3, 64'hC000_0000);
    wr(4'd0, (64'd3 << 26) | 64'd1);
    idle(20);
    wr(4'd0, (64'd3 << 26) | 64'd1);
    rd(4'd9, v); chk("R5 raw ns after add", v, m_ns);
    idle(20);

    cur_req = "R6";
    wr(4'd2, 64'd800);
    wr(4'd3, 64'hE000_0000);
    wr(4'd0, (64'd4 << 26) | 64'd1);
    idle(10);
    wr(4'd0, (64'd4 << 26) | 64'd1);
    rd(4'd9, v); chk("R6 raw ns after subtract", v, m_ns);
    idle(10);

    cur_req = "R8";
    wr(4'd0, 64'd0);
    wr(4'd2, 64'd50000);
    wr(4'd0, 64'd2 << 26);
    idle(5);
    wr(4'd0, 64'd7 << 26);
    rd(4'd0, v); chk("R8 op cleared after bad code", v, 64'd0);
    rd(4'd9, v); chk("R8 bad code leaves ns", v, m_ns);
    idle(5);

    cur_req = "R4 no-enable";
    do_set(64'd3999, 32'h0, 1'b0);
    idle(5);
    rd(4'd8, v); chk("R4 load with enable off", v, {32'd3, 32'd999});

    cur_req = "R7";
    wr(4'd2, 64'd1000000000);
    wr(4'd3, 64'd0);
    wr(4'd0, 64'd4 << 26);
    rd(4'd8, v); chk("R7 saturated tstamp", v, 64'd0);
    rd(4'd9, v); chk("R7 saturated ns", v, 64'd0);
    wr(4'd0, 64'd1);
    idle(300);
    rd(4'd9, v); chk("R3 raw ns after saturate run", v, m_ns);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all R act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule